// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block guards a system against runaway software with a 7-bit down-counter. Software must refresh the counter inside a time window. The window is bounded above by a programmable value and below by the fixed count 0x40. Two faults raise a single-cycle reset request: a counter that decays past the lower bound, and a refresh that arrives while the count is still above the programmed upper bound. The counter steps down once every `BASE_DIV << presc_sel_i` clock cycles.

Before arming, software can preload the counter with a refresh strobe. It then arms the block with a one-cycle `arm_i` pulse. After that, it reloads the counter periodically with `refresh_i` and `refresh_val_i`. The only ways to disarm the block are the module reset and the block's own reset request.

The controller has three states:
- `ST_IDLE`: disarmed. The counter holds its value.
- `ST_RUN`: armed and counting.
- `ST_FIRE`: the one-cycle reset pulse.

The transitions are:
- `ST_IDLE`→`ST_RUN` on arm.
- `ST_RUN`→`ST_FIRE` on underflow or on an early refresh.
- `ST_FIRE`→`ST_IDLE` unconditionally.
- `ST_IDLE` and `ST_RUN` otherwise stay where they are.

Top module: `wwdg_top`

## Requirements
- R1: After the module reset, `wdg_rst_o` is 0. The block is disarmed, and both the counter and the window register hold 0x7F.
- R2: While disarmed, the counter does not move and no reset request is raised. A refresh strobe loads `refresh_val_i` into the counter with no window check.
- R3: A single-cycle `arm_i` pulse arms the block. Lowering `arm_i` afterwards has no effect. Only the module reset or a reset request disarms it.
- R4: While armed, the counter decrements once every `BASE_DIV * 2^presc_sel_i` cycles. The encoding is 0→×1, 1→×2, 2→×4, 3→×8. The divider restarts from zero on arming and on every accepted refresh.
- R5: A decrement applied while the count is 0x40 or lower raises the reset request. From count C ≥ 0x40 this happens `BASE_DIV*2^sel*(C-0x3F)` cycles after arming. A loaded value below 0x40 fires at the first decrement.
- R6: A refresh while armed and while the count is strictly above the window register raises the reset request in the cycle after the strobe.
- R7: A refresh while armed and while the count is at or below the window register is accepted. It loads `refresh_val_i` and raises no reset request.
- R8: The reset request lasts exactly one cycle. The block then returns to the disarmed state, with counter and window both 0x7F.
- R9: `win_wr_i` captures `win_val_i` into the window register at any time outside the reset pulse.
- R10: When a refresh and a divider tick occur in the same cycle, the refresh is handled and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous module reset |
| arm_i | input | 1 | Arm strobe; arming is sticky |
| refresh_i | input | 1 | Refresh strobe |
| refresh_val_i | input | 7 | Counter value loaded by a refresh |
| win_wr_i | input | 1 | Window register write strobe |
| win_val_i | input | 7 | New upper window bound |
| presc_sel_i | input | 2 | Divider select: ×1, ×2, ×4, ×8 of BASE_DIV |
| wdg_rst_o | output | 1 | One-cycle reset request |

## Verification
The assertions take `refresh_i` and `arm_i` to be synchronous single-cycle strobes. They also take `presc_sel_i` to be steady while the block is armed, because each expected fire time depends on a fixed divide ratio. The stimulus satisfies this in two ways:
- It changes the select and loads the counter only while the block is disarmed.
- It drives every strobe for exactly one clock at the falling edge.

The bench builds the block with a small base divider, so that a full decay from 0x7F fits in a few hundred cycles.

// File: rtl/wwdg_pkg.sv
package wwdg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wd_state_t;
endpackage

// File: rtl/wwdg_prescaler.sv
module wwdg_prescaler #(
    parameter int BASE_DIV = 4096,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int MAX_SHIFT = (1 << SEL_W) - 1;
    localparam int PCNT_W    = $clog2(BASE_DIV << MAX_SHIFT);

    logic [PCNT_W-1:0] pcnt_q;
    logic [PCNT_W-1:0] limit;

    always_comb begin
        limit  = PCNT_W'((BASE_DIV << sel_i) - 1);
        tick_o = run_i && (pcnt_q >= limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || restart_i) begin
            pcnt_q <= '0;
        end else if (pcnt_q >= limit) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wwdg_counter.sv
module wwdg_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    input  logic             win_wr_i,
    input  logic [CNT_W-1:0] win_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] win_o,
    output logic             floor_o,
    output logic             early_o
);
    localparam logic [CNT_W-1:0] LOW_LIMIT = CNT_W'(1) << (CNT_W - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] win_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '1;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            win_q <= '1;
        end else if (win_wr_i) begin
            win_q <= win_val_i;
        end
    end

    always_comb begin
        cnt_o   = cnt_q;
        win_o   = win_q;
        floor_o = (cnt_q <= LOW_LIMIT);
        early_o = (cnt_q > win_q);
    end
endmodule

// File: rtl/wwdg_fsm.sv
module wwdg_fsm
    import wwdg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      arm_i,
    input  logic      refresh_i,
    input  logic      tick_i,
    input  logic      early_i,
    input  logic      floor_i,
    output wd_state_t state_o,
    output logic      run_o,
    output logic      load_o,
    output logic      dec_o,
    output logic      restart_o,
    output logic      clear_o,
    output logic      fire_o
);
    wd_state_t state_q;
    wd_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (arm_i) state_d = ST_RUN;
            ST_RUN: begin
                if (refresh_i) begin
                    if (early_i) state_d = ST_FIRE;
                end else if (tick_i && floor_i) begin
                    state_d = ST_FIRE;
                end
            end
            ST_FIRE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        run_o     = 1'b0;
        load_o    = 1'b0;
        dec_o     = 1'b0;
        restart_o = 1'b0;
        clear_o   = 1'b0;
        fire_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = refresh_i;
            ST_RUN: begin
                run_o     = 1'b1;
                load_o    = refresh_i && !early_i;
                restart_o = refresh_i && !early_i;
                dec_o     = !refresh_i && tick_i && !floor_i;
            end
            ST_FIRE: begin
                clear_o = 1'b1;
                fire_o  = 1'b1;
            end
            default: clear_o = 1'b1;
        endcase
        state_o = state_q;
    end
endmodule

// File: rtl/wwdg_top.sv
module wwdg_top
    import wwdg_pkg::*;
#(
    parameter int BASE_DIV = 4096,
    parameter int CNT_W    = 7,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             refresh_i,
    input  logic [CNT_W-1:0] refresh_val_i,
    input  logic             win_wr_i,
    input  logic [CNT_W-1:0] win_val_i,
    input  logic [SEL_W-1:0] presc_sel_i,
    output logic             wdg_rst_o
);
    wd_state_t        state;
    logic             run, load, dec, restart, clear, fire, tick;
    logic             floor_hit, early;
    logic [CNT_W-1:0] cnt, win;

    wwdg_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (arm_i),
        .refresh_i (refresh_i),
        .tick_i    (tick),
        .early_i   (early),
        .floor_i   (floor_hit),
        .state_o   (state),
        .run_o     (run),
        .load_o    (load),
        .dec_o     (dec),
        .restart_o (restart),
        .clear_o   (clear),
        .fire_o    (fire)
    );

    wwdg_prescaler #(.BASE_DIV(BASE_DIV), .SEL_W(SEL_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .restart_i (restart),
        .sel_i     (presc_sel_i),
        .tick_o    (tick)
    );

    wwdg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .load_i     (load),
        .load_val_i (refresh_val_i),
        .dec_i      (dec),
        .win_wr_i   (win_wr_i),
        .win_val_i  (win_val_i),
        .cnt_o      (cnt),
        .win_o      (win),
        .floor_o    (floor_hit),
        .early_o    (early)
    );

    assign wdg_rst_o = fire;
endmodule

// File: rtl/wwdg_checker.sv
module wwdg_checker
    import wwdg_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             refresh_i,
    input logic [CNT_W-1:0] refresh_val_i,
    input logic             wdg_rst_o,
    input wd_state_t        state,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] win,
    input logic             tick
);
    localparam logic [CNT_W-1:0] LOW_LIMIT = CNT_W'(1) << (CNT_W - 1);

    assert_pulse_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_rst_o |=> !wdg_rst_o);

    assert_idle_holds_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !refresh_i) |=> $stable(cnt));

    assert_early_refresh_fires_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && refresh_i && cnt > win) |=> wdg_rst_o);

    assert_valid_refresh_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && refresh_i && cnt <= win) |=> (cnt == $past(refresh_val_i) && !wdg_rst_o));

    assert_underflow_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !refresh_i && tick && cnt <= LOW_LIMIT) |=> wdg_rst_o);

    assert_armed_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> (state == ST_RUN || state == ST_FIRE));

    assert_fire_restores_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_rst_o |=> (state == ST_IDLE && cnt == '1 && win == '1));
endmodule

bind wwdg_top wwdg_checker #(.CNT_W(CNT_W)) u_wwdg_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .refresh_i     (refresh_i),
    .refresh_val_i (refresh_val_i),
    .wdg_rst_o     (wdg_rst_o),
    .state         (state),
    .cnt           (cnt),
    .win           (win),
    .tick          (tick)
);

// File: tb/test_wwdg_top.sv
module test_wwdg_top;
    localparam int BASE = 4;
    localparam int NV   = 6;
    localparam logic [1:0] V_SEL [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd0};
    localparam logic [6:0] V_VAL [NV] = '{7'h42, 7'h45, 7'h40, 7'h43, 7'h7F, 7'h30};
    localparam int         V_EXP [NV] = '{12, 48, 16, 128, 256, 4};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arm_i = 1'b0;
    logic       refresh_i = 1'b0;
    logic [6:0] refresh_val_i = '0;
    logic       win_wr_i = 1'b0;
    logic [6:0] win_val_i = '0;
    logic [1:0] presc_sel_i = '0;
    logic       wdg_rst_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int got;

    always #10 clk = ~clk;

    wwdg_top #(.BASE_DIV(BASE)) i_wwdg_top (
        .clk           (clk),
        .rst_n         (rst_n),
        .arm_i         (arm_i),
        .refresh_i     (refresh_i),
        .refresh_val_i (refresh_val_i),
        .win_wr_i      (win_wr_i),
        .win_val_i     (win_val_i),
        .presc_sel_i   (presc_sel_i),
        .wdg_rst_o     (wdg_rst_o)
    );

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_refresh(input logic [6:0] v);
        refresh_val_i = v;
        refresh_i = 1'b1;
        step();
        refresh_i = 1'b0;
    endtask

    task automatic do_arm();
        arm_i = 1'b1;
        step();
        arm_i = 1'b0;
    endtask

    task automatic set_window(input logic [6:0] v);
        win_val_i = v;
        win_wr_i = 1'b1;
        step();
        win_wr_i = 1'b0;
    endtask

    // cycles from the last sampled edge to the first reset pulse; -1 if none
    task automatic wait_fire(input int limit, output int n);
        n = -1;
        for (int i = 1; i <= limit; i++) begin
            step();
            if (wdg_rst_o) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic no_pulse_for(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (wdg_rst_o) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    initial begin
        steps(3);
        // R1: reset state, request low
        check(wdg_rst_o == 1'b0, "R1 reset output", int'(wdg_rst_o), 0);
        rst_n = 1'b1;
        step();
        // R2: disarmed block never fires, even with a small preloaded count
        do_refresh(7'h30);
        no_pulse_for(300, "R2 idle no pulse");

        // R4/R5 vector table
        for (int v = 0; v < NV; v++) begin
            presc_sel_i = V_SEL[v];
            do_refresh(V_VAL[v]);
            do_arm();
            wait_fire(400, got);
            check(got == V_EXP[v], $sformatf("R4 R5 vector %0d fire time", v), got, V_EXP[v]);
            step();
            check(wdg_rst_o == 1'b0, "R8 pulse width", int'(wdg_rst_o), 0);
        end

        // R8: after a pulse the block is disarmed
        no_pulse_for(300, "R8 disarmed after pulse");

        // R1: reset window is 0x7F, so refresh at 0x7F is accepted
        presc_sel_i = 2'd0;
        do_arm();
        do_refresh(7'h42);
        check(wdg_rst_o == 1'b0, "R1 reset window accepts 0x7F", int'(wdg_rst_o), 0);
        wait_fire(100, got);
        check(got == 12, "R7 reload then decay", got, 12);
        step();

        // R6: early refresh with window 0x50 while count 0x7F
        set_window(7'h50);
        do_arm();
        do_refresh(7'h45);
        check(wdg_rst_o == 1'b1, "R6 early refresh fires", int'(wdg_rst_o), 1);
        step();
        check(wdg_rst_o == 1'b0, "R8 early pulse width", int'(wdg_rst_o), 0);

        // R8: window back to 0x7F after pulse, so refresh at count 0x7F accepted
        do_arm();
        do_refresh(7'h7F);
        check(wdg_rst_o == 1'b0, "R8 window restored", int'(wdg_rst_o), 0);
        no_pulse_for(20, "R8 window restored, still counting");
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        // R1: module reset disarms a running block
        no_pulse_for(400, "R1 reset disarms");

        // R9/R7: window equal to count is accepted (count 0x44, window 0x44)
        set_window(7'h44);
        do_refresh(7'h45);
        do_arm();
        steps(4);
        do_refresh(7'h41);
        check(wdg_rst_o == 1'b0, "R7 refresh at window edge", int'(wdg_rst_o), 0);
        wait_fire(100, got);
        check(got == 8, "R7 load after edge refresh", got, 8);
        step();

        // R10/R6: refresh on a tick edge with count 0x45 above window 0x44 is early
        set_window(7'h44);
        do_refresh(7'h45);
        do_arm();
        steps(3);
        do_refresh(7'h41);
        check(wdg_rst_o == 1'b1, "R10 refresh on tick sees old count", int'(wdg_rst_o), 1);
        step();

        // R10/R4: accepted refresh on a tick edge drops the tick and restarts the divider
        do_refresh(7'h42);
        do_arm();
        steps(3);
        do_refresh(7'h42);
        wait_fire(100, got);
        check(got == 12, "R10 refresh wins over tick", got, 12);
        step();

        // R9: window written while armed takes effect
        do_refresh(7'h60);
        do_arm();
        set_window(7'h50);
        do_refresh(7'h45);
        check(wdg_rst_o == 1'b1, "R9 live window write", int'(wdg_rst_o), 1);
        step();

        // R3: arm pulse then low input, block keeps counting to fire
        do_refresh(7'h41);
        do_arm();
        wait_fire(100, got);
        check(got == 8, "R3 sticky arm", got, 8);

        finish_run();
    end
endmodule